// File: doc/BRIEF.md
# Exception Priority Resolver for Paired Accesses

This block sits at the tail of a processor pipeline and decides which single exception is accepted for the instruction that is retiring. That instruction is either a lone instruction or a delayed branch fused with its delay-slot instruction, which are resolved as one indivisible unit. Each instruction presents a level-1 flag, eight memory fault flags, a level-2 completion-type flag, a level-3 flag and a level-4 flag. The eight memory fault flags cover two data transfers with four fault kinds each. The resolver ranks all of these and reports one winner.

The inputs are captured on a cycle where `sample` is high. The result appears on the registered outputs one clock later. The outputs give the cause code, the instruction that owns the exception (branch or slot) and the transfer index for memory faults. A tie indicator marks cases where the branch and the slot both raise the same level-3 or level-4 exception. Two further signals control the branch's link-register write: one suppresses it, and the other marks the link register contents as undefined because the write went ahead under a slot re-execution exception.

Top module: `exc_resolver`

## Requirements
- R1: A synchronous reset drives `exc_valid` low and every other output to zero.
- R2: Outputs update exactly one clock after a cycle with `sample` high. On cycles with `sample` low, all inputs are ignored and every output holds its value.
- R3: When no input flag of a participating instruction is set, `exc_valid` is 0 and `exc_cause` is 0.
- R4: For an unpaired instruction, the order from highest to lowest priority is as follows. The level-1 flag comes first. Next come the memory faults, where every transfer-0 fault beats every transfer-1 fault. Within one transfer the order is address error, TLB miss, protection violation, initial-page-write. After the memory faults come level-2 completion, then level 3, then level 4.
- R5: Cause codes are 1 for level 1 and 2/3/4/5 for address error, TLB miss, protection violation and initial-page-write. Level-2 completion is 6, level 3 is 7 and level 4 is 8. Causes 1 to 5 are re-execution type. `exc_xfer` gives the transfer of a memory fault and is 0 for every other cause. In `*_mem`, bit 4*t+k is fault kind k (0 address error, 1 TLB miss, 2 protection, 3 initial-page-write) of transfer t.
- R6: For a pair (`paired`=1), the branch's level-1 and memory faults come first, then the slot's level-1 and memory faults (slot transfer 0 before transfer 1). These are followed by the branch's level-2 completion and then the slot's level-2 completion.
- R7: For a pair, level 3 of both instructions is checked after all of the above and before level 4. At level 3 and at level 4, the branch and slot rank equally. The branch is then reported (`exc_owner`=0), and `exc_tie` is 1 only when both flags at the accepted level are set.
- R8: If a pair's accepted exception is a slot re-execution type (cause 1 to 5, owner slot), `lr_block` is 0 and `lr_undef` is 1.
- R9: For any other exception accepted in a pair, `lr_block` is 1 and `lr_undef` is 0. For an unpaired instruction, both are always 0.
- R10: When `paired` is 0, all slot inputs are ignored and `exc_owner` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample | input | 1 | Capture strobe for the inputs |
| paired | input | 1 | Branch and delay slot are resolved together |
| br_lvl1 | input | 1 | Branch level-1 interrupt/re-execution flag |
| br_mem | input | 8 | Branch memory faults, bit 4*t+k |
| br_cmp2 | input | 1 | Branch level-2 completion-type flag |
| br_lvl3 | input | 1 | Branch level-3 flag |
| br_lvl4 | input | 1 | Branch level-4 flag |
| sl_lvl1 | input | 1 | Slot level-1 interrupt/re-execution flag |
| sl_mem | input | 8 | Slot memory faults, bit 4*t+k |
| sl_cmp2 | input | 1 | Slot level-2 completion-type flag |
| sl_lvl3 | input | 1 | Slot level-3 flag |
| sl_lvl4 | input | 1 | Slot level-4 flag |
| exc_valid | output | 1 | An exception was accepted |
| exc_cause | output | 4 | Accepted cause code, 0 for none |
| exc_owner | output | 1 | 0 branch, 1 slot |
| exc_xfer | output | 1 | Transfer index of a memory fault |
| exc_tie | output | 1 | Branch and slot tied at accepted level |
| lr_block | output | 1 | Suppress the branch's link-register write |
| lr_undef | output | 1 | Link register contents undefined |

## Verification
Two decisions can land in the same cycle: the choice of the owning instruction, and the link-register outcome that follows from it. These are provoked by sweeping every pair of single-flag branch and slot patterns, plus many sparse random pairs. Those patterns put a slot re-execution fault beside a branch completion fault, and level-3 or level-4 ties beside link suppression. Each result is judged against a rank-minimum model, and `lr_block`, `lr_undef` and `exc_tie` are compared together with the cause and owner.

// File: rtl/exc_resolver.sv
module exc_resolver #(
  parameter int NXFER = 2,
  parameter int NKIND = 4,
  parameter int CW    = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sample,
  input  logic                   paired,
  input  logic                   br_lvl1,
  input  logic [NXFER*NKIND-1:0] br_mem,
  input  logic                   br_cmp2,
  input  logic                   br_lvl3,
  input  logic                   br_lvl4,
  input  logic                   sl_lvl1,
  input  logic [NXFER*NKIND-1:0] sl_mem,
  input  logic                   sl_cmp2,
  input  logic                   sl_lvl3,
  input  logic                   sl_lvl4,
  output logic                   exc_valid,
  output logic [CW-1:0]          exc_cause,
  output logic                   exc_owner,
  output logic [(NXFER>1 ? $clog2(NXFER) : 1)-1:0] exc_xfer,
  output logic                   exc_tie,
  output logic                   lr_block,
  output logic                   lr_undef
);
  localparam int MW = NXFER * NKIND;
  localparam int XW = NXFER > 1 ? $clog2(NXFER) : 1;
  localparam int KW = NKIND > 1 ? $clog2(NKIND) : 1;
  localparam int RW = 1 + XW + KW;
  localparam logic [CW-1:0] C_L1   = CW'(1);
  localparam int            C_MEM  = 2;
  localparam logic [CW-1:0] C_CMP2 = CW'(NKIND + 2);
  localparam logic [CW-1:0] C_L3   = CW'(NKIND + 3);
  localparam logic [CW-1:0] C_L4   = CW'(NKIND + 4);

  function automatic logic [RW-1:0] first_mem(input logic [MW-1:0] m);
    logic [RW-1:0] r;
    r = '0;
    for (int i = MW - 1; i >= 0; i--)
      if (m[i]) r = {1'b1, XW'(i / NKIND), KW'(i % NKIND)};
    return r;
  endfunction

  logic [RW-1:0]   bm, sm;
  logic [CW-1:0]   n_cause;
  logic            n_owner, n_tie, n_reexec;
  logic [XW-1:0]   n_xfer;

  assign bm = first_mem(br_mem);
  assign sm = first_mem(sl_mem);

  always_comb begin
    n_cause  = '0;
    n_owner  = 1'b0;
    n_xfer   = '0;
    n_tie    = 1'b0;
    n_reexec = 1'b0;
    if (br_lvl1) begin
      n_cause  = C_L1;
      n_reexec = 1'b1;
    end else if (bm[RW-1]) begin
      n_cause  = CW'(C_MEM + int'(bm[KW-1:0]));
      n_xfer   = bm[KW +: XW];
      n_reexec = 1'b1;
    end else if (paired && sl_lvl1) begin
      n_cause  = C_L1;
      n_owner  = 1'b1;
      n_reexec = 1'b1;
    end else if (paired && sm[RW-1]) begin
      n_cause  = CW'(C_MEM + int'(sm[KW-1:0]));
      n_xfer   = sm[KW +: XW];
      n_owner  = 1'b1;
      n_reexec = 1'b1;
    end else if (br_cmp2) begin
      n_cause  = C_CMP2;
    end else if (paired && sl_cmp2) begin
      n_cause  = C_CMP2;
      n_owner  = 1'b1;
    end else if (br_lvl3 || (paired && sl_lvl3)) begin
      n_cause  = C_L3;
      n_owner  = ~br_lvl3;
      n_tie    = br_lvl3 & paired & sl_lvl3;
    end else if (br_lvl4 || (paired && sl_lvl4)) begin
      n_cause  = C_L4;
      n_owner  = ~br_lvl4;
      n_tie    = br_lvl4 & paired & sl_lvl4;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_valid <= 1'b0;
      exc_cause <= '0;
      exc_owner <= 1'b0;
      exc_xfer  <= '0;
      exc_tie   <= 1'b0;
      lr_block  <= 1'b0;
      lr_undef  <= 1'b0;
    end else if (sample) begin
      exc_valid <= n_cause != '0;
      exc_cause <= n_cause;
      exc_owner <= n_owner;
      exc_xfer  <= n_xfer;
      exc_tie   <= n_tie;
      lr_block  <= paired && (n_cause != '0) && !(n_owner && n_reexec);
      lr_undef  <= paired && n_owner && n_reexec;
    end
  end
endmodule

module exc_resolver_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          sample,
  input logic          paired,
  input logic          exc_valid,
  input logic [CW-1:0] exc_cause,
  input logic          exc_owner,
  input logic          exc_tie,
  input logic          lr_block,
  input logic          lr_undef
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> !exc_valid && exc_cause == '0);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sample |=> $stable({exc_valid, exc_cause, exc_owner, exc_tie, lr_block, lr_undef}));

  // R3
  none_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !exc_valid |-> exc_cause == '0 && !lr_block && !lr_undef && !exc_tie);

  // R7
  tie_branch_chk: assert property (@(posedge clk) disable iff (rst)
    exc_tie |-> !exc_owner && (exc_cause == CW'(7) || exc_cause == CW'(8)));

  // R8
  undef_slot_chk: assert property (@(posedge clk) disable iff (rst)
    lr_undef |-> exc_owner && exc_cause >= CW'(1) && exc_cause <= CW'(5) && !lr_block);

  // R9
  lr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lr_block, lr_undef}));

  // R10
  solo_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (sample && !paired) |=> !exc_owner && !lr_block && !lr_undef);
endmodule

bind exc_resolver exc_resolver_chk #(.CW(CW)) u_chk (.*);

// File: tb/exc_resolver_bench.sv
`timescale 1ns/1ps
module exc_resolver_bench;
  logic clk = 1'b0, rst = 1'b1, sample = 1'b0, paired = 1'b0;
  logic [11:0] bv = '0, sv = '0;
  logic exc_valid, exc_owner, exc_tie, lr_block, lr_undef;
  logic [3:0] exc_cause;
  logic [0:0] exc_xfer;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  // vector layout: {lvl4, lvl3, cmp2, mem[7:0], lvl1}
  exc_resolver u_exc_resolver (
    .clk(clk), .rst(rst), .sample(sample), .paired(paired),
    .br_lvl1(bv[0]), .br_mem(bv[8:1]), .br_cmp2(bv[9]), .br_lvl3(bv[10]), .br_lvl4(bv[11]),
    .sl_lvl1(sv[0]), .sl_mem(sv[8:1]), .sl_cmp2(sv[9]), .sl_lvl3(sv[10]), .sl_lvl4(sv[11]),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_owner(exc_owner), .exc_xfer(exc_xfer),
    .exc_tie(exc_tie), .lr_block(lr_block), .lr_undef(lr_undef));

  function automatic int rank_of(input int bit_i, input int inst);
    if (bit_i == 0) return inst * 9;
    if (bit_i <= 8) return inst * 9 + bit_i;
    if (bit_i == 9) return 18 + inst;
    if (bit_i == 10) return 20;
    return 21;
  endfunction

  function automatic logic [9:0] model(input logic p, input logic [11:0] b, input logic [11:0] s);
    int best, bb, bi;
    logic tie, re;
    logic [3:0] c;
    best = 99; bb = -1; bi = 0; tie = 1'b0;
    for (int inst = 0; inst < 2; inst++) begin
      if (inst == 1 && !p) continue;
      for (int k = 0; k < 12; k++) begin
        logic [11:0] v;
        v = inst == 0 ? b : s;
        if (!v[k]) continue;
        if (rank_of(k, inst) < best) begin
          best = rank_of(k, inst); bb = k; bi = inst; tie = 1'b0;
        end else if (rank_of(k, inst) == best && inst == 1) tie = 1'b1;
      end
    end
    if (bb < 0) return '0;
    c = bb == 0 ? 4'd1 : bb <= 8 ? 4'(2 + (bb - 1) % 4) : 4'(bb - 3);
    re = c <= 4'd5;
    // {valid, cause, owner, xfer, tie, block, undef}
    return {1'b1, c, bi[0], (bb >= 5 && bb <= 8), tie,
            p && !(bi == 1 && re), p && bi == 1 && re};
  endfunction

  function automatic logic [9:0] outs();
    return {exc_valid, exc_cause, exc_owner, exc_xfer[0], exc_tie, lr_block, lr_undef};
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s p=%b b=%h s=%h actual=%b expected=%b", tag, paired, bv, sv, act, exp);
    end
  endtask

  task automatic apply(input logic p, input logic [11:0] b, input logic [11:0] s, input bit hold);
    logic [9:0] e;
    string tag;
    @(negedge clk);
    paired = p; bv = b; sv = s; sample = 1'b1;
    e = model(p, b, s);
    @(negedge clk);
    sample = 1'b0;
    if (!e[9]) tag = "R3";
    else if (!p) tag = "R4 R5 R10";
    else if (e[2]) tag = "R7";
    else if (e[0]) tag = "R8";
    else tag = "R6 R9";
    check(tag, outs(), e);
    if (hold) begin
      paired = ~p; bv = 12'($urandom); sv = 12'($urandom);
      @(negedge clk);
      check("R2 hold", outs(), e);
    end
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    // R1
    check("R1", outs(), '0);
    rst = 1'b0;
    // R3
    apply(1'b1, '0, '0, 1'b1);
    // R4 R5 R10: every unpaired pattern, slot inputs as noise
    for (int v = 0; v < 4096; v++) apply(1'b0, 12'(v), 12'($urandom), v % 64 == 0);
    // R6 R7 R8 R9: every single-flag branch/slot combination
    for (int i = -1; i < 12; i++)
      for (int j = -1; j < 12; j++)
        apply(1'b1, i < 0 ? 12'd0 : 12'(1 << i), j < 0 ? 12'd0 : 12'(1 << j), 1'b0);
    // sparse random pairs
    for (int n = 0; n < 4000; n++)
      apply(1'b1, 12'($urandom & $urandom & $urandom), 12'($urandom & $urandom), n % 97 == 0);
    // R1 mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1", outs(), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule